// File: doc/BRIEF.md
# Accumulator Processor with Interrupt Check

This block is a small single-accumulator processor core. It reads 16-bit instruction words from a word-addressed synchronous memory. Every access goes through an address holding register and a data buffer register. Each instruction word carries a 4-bit operation code in bits 15:12 and a 12-bit memory address in bits 11:0. The core can load the accumulator from memory, add a memory word to it, write it back to memory, jump, and return from an interrupt handler. Every other code does nothing.

Each instruction passes through a fixed state sequence: fetch, decode, operand access (when the instruction needs one), execute, and an interrupt check. In the interrupt check the core samples its request input. If a request is present and interrupts are enabled, the core saves the address of the next instruction. It then redirects the program counter to a fixed handler address, disables interrupts and raises an acknowledge for one cycle. The memory is expected to return read data in the cycle after the read strobe.

Top module: `acc_cpu`

## Requirements
- R1: While reset is held, no read, write or acknowledge is driven. After reset the first instruction read is from address RESET_PC, and interrupts start enabled.
- R2: A fetch takes four cycles: one idle cycle, a read strobe at the PC address, a capture cycle and a decode cycle. The PC then steps by one modulo 4096, so address 0xFFF is followed by 0x000.
- R3: Code 0x1 (bits 15:12) reads the word at the address in bits 11:0, in the cycle after decode, and places it in the accumulator.
- R4: Code 0x5 reads the addressed word and adds it to the accumulator modulo 2^16.
- R5: Code 0x2 drives a single write strobe with the address in bits 11:0 and the accumulator value as write data. Read and write are never asserted together.
- R6: Code 0x8 makes the next fetch read address bits 11:0 instead of PC+1.
- R7: Every code other than 0x1, 0x2, 0x5, 0x8 and 0xF makes no memory access, and the next fetch comes from PC+1.
- R8: In the check cycle after execute, a high request with interrupts enabled raises the acknowledge for exactly one cycle. The following fetch reads HANDLER_PC (default 0x0F0), the PC of the next instruction is saved, and interrupts are disabled.
- R9: While interrupts are disabled, a high request gives no acknowledge and does not change the fetch sequence.
- R10: Code 0xF restores the saved PC as the next fetch address and enables interrupts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 12 | Memory word address (address register) |
| mem_wdata | output | 16 | Memory write data (buffer register) |
| mem_rdata | input | 16 | Memory read data, valid the cycle after a read strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| irq | input | 1 | Interrupt request, level, synchronous |
| irq_ack | output | 1 | One-cycle interrupt acknowledge |

## Verification
The assertions assume that memory read data arrives exactly one cycle after the read strobe. They also assume that the request input changes only away from the rising clock edge. The bench memory registers its read data on the edge that sees the strobe. The request is driven at the falling edge from a fixed schedule of cycle windows. One of these windows is long enough to stay high through a whole handler, so requests that arrive while interrupts are disabled are covered.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  typedef enum logic [3:0] {
    ST_FADR, ST_FRD, ST_FCAP, ST_DEC,
    ST_ORD, ST_OCAP, ST_OWR, ST_EXE, ST_INT
  } state_t;

  typedef enum logic [2:0] {
    OP_NOP, OP_LOAD, OP_ADD, OP_STORE, OP_JUMP, OP_RETI
  } op_t;

  localparam logic [3:0] CODE_LOAD  = 4'h1;
  localparam logic [3:0] CODE_STORE = 4'h2;
  localparam logic [3:0] CODE_ADD   = 4'h5;
  localparam logic [3:0] CODE_JUMP  = 4'h8;
  localparam logic [3:0] CODE_RETI  = 4'hF;

  function automatic op_t op_decode(input logic [3:0] code);
    case (code)
      CODE_LOAD:  return OP_LOAD;
      CODE_STORE: return OP_STORE;
      CODE_ADD:   return OP_ADD;
      CODE_JUMP:  return OP_JUMP;
      CODE_RETI:  return OP_RETI;
      default:    return OP_NOP;
    endcase
  endfunction

endpackage

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  op_t    op_now,
  input  logic   irq,
  input  logic   int_en,
  output state_t state,
  output logic   take_int,
  output logic   rd_cyc,
  output logic   wr_cyc
);

  state_t nxt;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FADR;
    else     state <= nxt;
  end

  always_comb begin
    nxt = state;
    case (state)
      ST_FADR: nxt = ST_FRD;
      ST_FRD:  nxt = ST_FCAP;
      ST_FCAP: nxt = ST_DEC;
      ST_DEC: begin
        if (op_now == OP_LOAD || op_now == OP_ADD) nxt = ST_ORD;
        else if (op_now == OP_STORE)               nxt = ST_OWR;
        else                                       nxt = ST_EXE;
      end
      ST_ORD:  nxt = ST_OCAP;
      ST_OCAP: nxt = ST_EXE;
      ST_OWR:  nxt = ST_EXE;
      ST_EXE:  nxt = ST_INT;
      ST_INT:  nxt = ST_FADR;
      default: nxt = ST_FADR;
    endcase
  end

  assign take_int = (state == ST_INT) && irq && int_en;
  assign rd_cyc   = (state == ST_FRD) || (state == ST_ORD);
  assign wr_cyc   = (state == ST_OWR);

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rd_cyc && wr_cyc)); // R5
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    take_int |=> !take_int); // R8
  AST_ACK_THEN_FETCH: assert property (@(posedge clk) disable iff (rst)
    take_int |=> (state == ST_FADR)); // R8

endmodule

// File: rtl/acc_cpu_dpath.sv
module acc_cpu_dpath
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] RESET_PC   = '0,
  parameter logic [ADDR_W-1:0] HANDLER_PC = 'h0F0
)(
  input  logic              clk,
  input  logic              rst,
  input  state_t            state,
  input  logic              take_int,
  input  logic [DATA_W-1:0] mem_rdata,
  output op_t               op_now,
  output logic              int_en,
  output logic [ADDR_W-1:0] mar_q,
  output logic [DATA_W-1:0] mbr_q
);

  localparam int OP_W = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] pc_q, saved_q;
  logic [DATA_W-1:0] ir_q, acc_q;
  op_t               op_ir;

  function automatic logic [ADDR_W-1:0] pc_step(input logic [ADDR_W-1:0] p);
    return p + {{(ADDR_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [DATA_W-1:0] acc_sum(input logic [DATA_W-1:0] a,
                                                input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  assign op_ir  = op_decode(ir_q[DATA_W-1 -: OP_W]);
  assign op_now = (state == ST_DEC) ? op_decode(mbr_q[DATA_W-1 -: OP_W]) : op_ir;

  // named events for the checks below
  logic dec_ev, fetch_rd_ev, reti_ev, store_ev;
  assign dec_ev      = (state == ST_DEC);
  assign fetch_rd_ev = (state == ST_FRD);
  assign reti_ev     = (state == ST_EXE) && (op_ir == OP_RETI);
  assign store_ev    = (state == ST_OWR);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= RESET_PC;
      saved_q <= '0;
      mar_q   <= '0;
      mbr_q   <= '0;
      ir_q    <= '0;
      acc_q   <= '0;
      int_en  <= 1'b1;
    end else begin
      case (state)
        ST_FADR: mar_q <= pc_q;
        ST_FCAP: mbr_q <= mem_rdata;
        ST_DEC: begin
          ir_q  <= mbr_q;
          pc_q  <= pc_step(pc_q);
          mar_q <= mbr_q[ADDR_W-1:0];
          mbr_q <= acc_q;
        end
        ST_OCAP: mbr_q <= mem_rdata;
        ST_EXE: begin
          case (op_ir)
            OP_LOAD: acc_q <= mbr_q;
            OP_ADD:  acc_q <= acc_sum(acc_q, mbr_q);
            OP_JUMP: pc_q  <= ir_q[ADDR_W-1:0];
            OP_RETI: begin
              pc_q   <= saved_q;
              int_en <= 1'b1;
            end
            default: ;
          endcase
        end
        ST_INT: begin
          if (take_int) begin
            saved_q <= pc_q;
            pc_q    <= HANDLER_PC;
            int_en  <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    dec_ev |=> (pc_q == pc_step($past(pc_q)))); // R2
  AST_FETCH_AT_PC: assert property (@(posedge clk) disable iff (rst)
    fetch_rd_ev |-> (mar_q == pc_q)); // R2
  AST_STORE_DATA: assert property (@(posedge clk) disable iff (rst)
    store_ev |-> (mbr_q == acc_q)); // R5
  AST_HANDLER_ENTRY: assert property (@(posedge clk) disable iff (rst)
    take_int |=> (pc_q == HANDLER_PC) && !int_en && (saved_q == $past(pc_q))); // R8
  AST_NO_TAKE_MASKED: assert property (@(posedge clk) disable iff (rst)
    !int_en |-> !take_int); // R9
  AST_RETI_RESTORE: assert property (@(posedge clk) disable iff (rst)
    reti_ev |=> int_en && (pc_q == $past(saved_q))); // R10

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter logic [DATA_W-5:0] RESET_PC   = '0,
  parameter logic [DATA_W-5:0] HANDLER_PC = 'h0F0
)(
  input  logic              clk,
  input  logic              rst,
  output logic [DATA_W-5:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_rd,
  output logic              mem_wr,
  input  logic              irq,
  output logic              irq_ack
);

  localparam int ADDR_W = DATA_W - 4;

  state_t state;
  op_t    op_now;
  logic   int_en, take_int;

  acc_cpu_ctrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .op_now   (op_now),
    .irq      (irq),
    .int_en   (int_en),
    .state    (state),
    .take_int (take_int),
    .rd_cyc   (mem_rd),
    .wr_cyc   (mem_wr)
  );

  acc_cpu_dpath #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .RESET_PC   (RESET_PC),
    .HANDLER_PC (HANDLER_PC)
  ) i_dpath (
    .clk       (clk),
    .rst       (rst),
    .state     (state),
    .take_int  (take_int),
    .mem_rdata (mem_rdata),
    .op_now    (op_now),
    .int_en    (int_en),
    .mar_q     (mem_addr),
    .mbr_q     (mem_wdata)
  );

  assign irq_ack = take_int;

endmodule

// File: tb/test_acc_cpu.sv
module test_acc_cpu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        mem_rd, mem_wr;
  logic        irq = 1'b0;
  logic        irq_ack;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  acc_cpu i_acc_cpu (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .irq(irq), .irq_ack(irq_ack)
  );

  // memory seen by the design: read data one cycle after the strobe
  logic [15:0] mem [0:4095];
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) mem[mem_addr] <= mem_wdata;
  end

  typedef struct {
    bit          rd;
    bit          wr;
    logic [11:0] addr;
    logic [15:0] wd;
    bit          ack;
    string       tag;
  } exp_t;

  exp_t        q[$];
  logic [15:0] m [0:4095];

  function automatic bit irq_at(int c);
    return (c >= 40 && c <= 41) || (c >= 200 && c <= 400) ||
           (c >= 1000 && c <= 1005) || (c >= 2000 && c <= 2100);
  endfunction

  task automatic push(bit rd, bit wr, logic [11:0] a, logic [15:0] d, bit ack, string tag);
    exp_t e;
    e.rd = rd; e.wr = wr; e.addr = a; e.wd = d; e.ack = ack; e.tag = tag;
    q.push_back(e);
  endtask

  // behavioural instruction-level model expanded into per-cycle bus activity
  task automatic run_model(int ncyc);
    int          pc = 0, saved = 0, acc = 0;
    bit          ie = 1'b1;
    string       why = "R1";
    logic [15:0] w;
    int          code, a;
    while (q.size() < ncyc) begin
      push(0, 0, 0, 0, 0, why);                  // idle cycle
      push(1, 0, 12'(pc), 0, 0, why);            // instruction read
      push(0, 0, 0, 0, 0, why);                  // capture
      push(0, 0, 0, 0, 0, why);                  // decode
      w = m[pc];
      code = int'(w[15:12]);
      a = int'(w[11:0]);
      pc = (pc + 1) % 4096;
      why = "R2";
      if (code == 1 || code == 5) begin
        push(1, 0, 12'(a), 0, 0, (code == 1) ? "R3" : "R4");
        push(0, 0, 0, 0, 0, "R3");
        if (code == 1) acc = int'(m[a]);
        else           acc = (acc + int'(m[a])) % 65536;
      end else if (code == 2) begin
        push(0, 1, 12'(a), 16'(acc), 0, "R5");
        m[a] = 16'(acc);
      end else if (code == 8) begin
        pc = a; why = "R6";
      end else if (code == 15) begin
        pc = saved; ie = 1'b1; why = "R10";
      end else begin
        why = "R7";
      end
      push(0, 0, 0, 0, 0, why);                  // execute
      if (irq_at(q.size()) && ie) begin
        push(0, 0, 0, 0, 1, "R8");
        saved = pc; pc = 'h0F0; ie = 1'b0; why = "R8";
      end else begin
        push(0, 0, 0, 0, 0, irq_at(q.size()) ? "R9" : why);
        if (irq_at(q.size() - 1)) why = "R9";
      end
    end
  endtask

  task automatic chk(bit ok, string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
    mem[12'h000] = 16'h1100;  // load 0x100
    mem[12'h001] = 16'h5101;  // add 0x101
    mem[12'h002] = 16'h2102;  // store 0x102
    mem[12'h003] = 16'h3000;  // unused code
    mem[12'h004] = 16'h5101;  // add 0x101
    mem[12'h005] = 16'h2103;  // store 0x103
    mem[12'h006] = 16'h8FFF;  // jump 0xFFF
    mem[12'hFFF] = 16'hE000;  // unused code, PC wraps to 0
    mem[12'h0F0] = 16'h1110;  // handler
    mem[12'h0F1] = 16'h5111;
    mem[12'h0F2] = 16'h2112;
    mem[12'h0F3] = 16'hF000;  // return
    mem[12'h100] = 16'h1234;
    mem[12'h101] = 16'hF00F;
    mem[12'h110] = 16'h00AA;
    mem[12'h111] = 16'hFF80;
    for (int i = 0; i < 4096; i++) m[i] = mem[i];
    run_model(3000);

    repeat (3) begin
      @(negedge clk);
      chk(!mem_rd && !mem_wr && !irq_ack, "R1", "idle in reset",
          {13'b0, mem_rd, mem_wr, irq_ack}, 16'h0);
    end
    rst = 1'b0;
    for (int c = 0; c < q.size(); c++) begin
      irq = irq_at(c);
      #1;
      chk(mem_rd == q[c].rd, q[c].tag, "mem_rd", 16'(mem_rd), 16'(q[c].rd));
      chk(mem_wr == q[c].wr, q[c].tag, "mem_wr", 16'(mem_wr), 16'(q[c].wr));
      chk(irq_ack == q[c].ack, q[c].tag, "irq_ack", 16'(irq_ack), 16'(q[c].ack));
      if (q[c].rd || q[c].wr)
        chk(mem_addr == q[c].addr, q[c].tag, "mem_addr", 16'(mem_addr), 16'(q[c].addr));
      if (q[c].wr)
        chk(mem_wdata == q[c].wd, q[c].tag, "mem_wdata", mem_wdata, q[c].wd);
      @(negedge clk);
    end
    chk(mem[12'h102] == m[12'h102], "R4", "stored sum", mem[12'h102], m[12'h102]);
    chk(mem[12'h112] == m[12'h112], "R5", "handler store", mem[12'h112], m[12'h112]);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule